// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder with Start/Finish Handshake

This block adds two unsigned words of `N` bits using a single full adder that is reused once per clock. A start request captures both operands in parallel. Shift registers then present the operand bits to the adder one at a time, least significant first. A carry flip-flop links each bit position to the next. The sum bits are shifted into a result register from its top end, so after `N` steps every bit lands in its proper position.

A small controller in algorithmic state machine form sequences the datapath, and it is kept separate from the datapath logic. It has three states: waiting, adding and finished. A bit counter is compared against `N` to decide when the adding phase ends. Each state's register transfers all take effect on the clock edge that leaves that state.

The handshake works as follows. The requester raises `go` and may keep it high. Once the adding has started, `go` is not looked at. When the result is ready, `done` rises and stays high for as long as `go` is held. The requester reads `sum` and `carry_out`, then lowers `go`. The block returns to waiting on the next edge, so a `go` level that is never released cannot start a second addition. Ready-style back-pressure does not apply: the requester controls the pace by choosing when it releases `go`.

Top module: `serial_adder_asm`

## Requirements
- R1: While the controller is waiting and `go` is 0, `sum`, `carry_out` and `done` do not change, whatever the operand inputs do.
- R2: `opnd_a` and `opnd_b` are captured on the edge where `go` is sampled at 1 in the waiting state. Changes to them after that edge do not affect the result.
- R3: The carry flip-flop and the bit counter are cleared on that capture edge, so bit 0 is added with a carry-in of 0 even if the previous result had `carry_out` = 1.
- R4: When `done` is 1, `{carry_out, sum}` equals `opnd_a + opnd_b` computed to `N+1` bits. Bit 0 of the result is `sum[0]`.
- R5: The bit counter goes up by one on each adding cycle and never exceeds `N`. `done` first reads 1 after the (N+1)th clock edge following the capture edge, which is N+2 edges after `go` is first sampled.
- R6: While `done` is 1 and `go` is 1, `done` stays 1 and `sum` and `carry_out` hold steady.
- R7: When `done` is 1 and `go` is 0 at an edge, `done` is 0 after that edge and the result outputs keep their value. A single long `go` level produces only one addition.
- R8: Once adding has begun, the value of `go` does not affect it. A one-cycle `go` pulse still produces a full, correct result and `done` appears.
- R9: Synchronous active-high `rst` returns the controller to waiting and clears `done`, the counter, `carry_out` and `sum` on the next edge, even in the middle of an addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request; also acknowledges the result when lowered |
| opnd_a | input | N | First operand, sampled on the start edge |
| opnd_b | input | N | Second operand, sampled on the start edge |
| sum | output | N | Low N bits of the result |
| carry_out | output | 1 | Carry out of the top bit |
| done | output | 1 | Result valid; held until go is released |

## Verification
A carry that is not cleared, or a shift with the bits in the wrong order, shows up as a wrong `{carry_out, sum}` the first time `done` rises, which is N+2 cycles after start. An operand pair that yields a carry is therefore followed at once by 0+0. An off-by-one in the counter or in the compare moves the rising edge of `done` by a cycle, so the bench counts that latency exactly. A handshake state that leaks shows up within one cycle: `done` fails to drop after `go` is released, or the result changes while the block is waiting.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_ADD  = 2'd1,
    ST_FIN  = 2'd2
  } sadd_state_e;
endpackage

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
  import sadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic        cnt_end,
  output logic        load,
  output logic        step,
  output logic        done,
  output sadd_state_e state
);
  sadd_state_e nxt;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    step = 1'b0;
    unique case (state)
      ST_WAIT: if (go) begin
        load = 1'b1;
        nxt  = ST_ADD;
      end
      ST_ADD: begin
        if (cnt_end) nxt = ST_FIN;
        else         step = 1'b1;
      end
      ST_FIN: if (!go) nxt = ST_WAIT;
      default: nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else     state <= nxt;
  end

  assign done = (state == ST_FIN);
endmodule

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic         lsb
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
    else if (step) q <= {1'b0, q[W-1:1]};
  end

  assign lsb = q[0];
endmodule

// File: rtl/sadd_bitcnt.sv
module sadd_bitcnt #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_end
);
  localparam logic [CW-1:0] LAST = CW'(N);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign at_end = (cnt == LAST);
endmodule

// File: rtl/sadd_slice.sv
module sadd_slice #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         a_bit,
  input  logic         b_bit,
  output logic [N-1:0] sum,
  output logic         carry
);
  logic s_bit, c_nxt;

  assign s_bit = a_bit ^ b_bit ^ carry;
  assign c_nxt = (a_bit & b_bit) | (carry & (a_bit ^ b_bit));

  always_ff @(posedge clk) begin
    if (rst || clr) carry <= 1'b0;
    else if (step)  carry <= c_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)       sum <= '0;
    else if (step) sum <= {s_bit, sum[N-1:1]};
  end
endmodule

// File: rtl/serial_adder_asm.sv
module serial_adder_asm
  import sadd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [N-1:0] opnd_a,
  input  logic [N-1:0] opnd_b,
  output logic [N-1:0] sum,
  output logic         carry_out,
  output logic         done
);
  localparam int CW = $clog2(N + 1);
  localparam int NOP = 2;

  logic          load, step, cnt_end;
  logic [CW-1:0] cnt;
  sadd_state_e   st;
  logic [N-1:0]  opnd [NOP];
  logic [NOP-1:0] bits;

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  sadd_ctrl i_ctrl (
    .clk(clk), .rst(rst), .go(go), .cnt_end(cnt_end),
    .load(load), .step(step), .done(done), .state(st)
  );

  for (genvar g = 0; g < NOP; g++) begin : g_opnd
    sadd_shreg #(.W(N)) i_sh (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .din(opnd[g]), .lsb(bits[g])
    );
  end

  sadd_bitcnt #(.N(N), .CW(CW)) i_cnt (
    .clk(clk), .rst(rst), .clr(load), .inc(step),
    .cnt(cnt), .at_end(cnt_end)
  );

  sadd_slice #(.N(N)) i_slice (
    .clk(clk), .rst(rst), .clr(load), .step(step),
    .a_bit(bits[0]), .b_bit(bits[1]),
    .sum(sum), .carry(carry_out)
  );
endmodule

// File: rtl/sadd_chk.sv
module sadd_chk
  import sadd_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic          done,
  input logic [N-1:0]  sum,
  input logic          carry_out,
  input sadd_state_e   state,
  input logic [CW-1:0] cnt
);
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !go) |=> ($stable(sum) && $stable(carry_out) && !done)); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && go) |=> (cnt == '0 && !carry_out && state == ST_ADD)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADD && cnt != CW'(N)) |=> (cnt == CW'($past(cnt) + 1'b1))); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(N)); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && go) |=> (done && $stable(sum) && $stable(carry_out))); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> (!done && $stable(sum))); // R7
  AST_ADD_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADD) |=> (state != ST_WAIT)); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!done && cnt == '0 && !carry_out && sum == '0)); // R9
endmodule

bind serial_adder_asm sadd_chk #(.N(N), .CW(CW)) i_sadd_chk (
  .clk(clk), .rst(rst), .go(go), .done(done), .sum(sum),
  .carry_out(carry_out), .state(st), .cnt(cnt)
);

// File: tb/test_serial_adder_asm.sv
module test_serial_adder_asm;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go  = 1'b0;
  logic [N-1:0] opnd_a = '0, opnd_b = '0;
  logic [N-1:0] sum;
  logic         carry_out, done;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_adder_asm #(.N(N)) i_serial_adder_asm (
    .clk(clk), .rst(rst), .go(go), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .sum(sum), .carry_out(carry_out), .done(done)
  );

  function automatic logic [N:0] ref_add(logic [N-1:0] a, logic [N-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_add(logic [N-1:0] a, logic [N-1:0] b, bit pulse);
    logic [N:0] exp = ref_add(a, b);
    logic [N:0] held;
    int n = 0;
    opnd_a = a; opnd_b = b; go = 1'b1;
    do begin
      tick();
      n++;
      if (n == 1) begin
        opnd_a = ~a; opnd_b = a ^ b;          // R2: post-capture changes
        if (pulse) go = 1'b0;                 // R8
      end
    end while (!done && n < N + 10);
    chk(n == N + 2, "R5", "edges to done", n, N + 2);
    chk({carry_out, sum} == exp, pulse ? "R8" : "R4", "result", {carry_out, sum}, exp);
    held = {carry_out, sum};
    if (!pulse) begin
      for (int k = 0; k < 3; k++) tick();
      chk(done && {carry_out, sum} == held, "R6", "held result", {done, carry_out, sum}, {1'b1, held});
      go = 1'b0;
    end
    tick();
    chk(!done, "R7", "done after release", done, 0);
    chk({carry_out, sum} == held, "R7", "result kept", {carry_out, sum}, held);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [N:0] prev;
    void'($urandom(32'h5EED_1234));
    tick(); tick(); tick();
    chk(sum == 0 && !carry_out && !done, "R9", "reset outputs", {done, carry_out, sum}, 0);
    rst = 1'b0;
    tick();

    prev = {carry_out, sum};
    for (int k = 0; k < 5; k++) begin
      opnd_a = N'($urandom); opnd_b = N'($urandom);
      tick();
      chk({carry_out, sum} == prev && !done, "R1", "idle hold", {done, carry_out, sum}, prev);
    end

    do_add('0, '0, 1'b0);
    do_add('1, '1, 1'b0);
    do_add('1, N'(1), 1'b0);
    do_add('0, '0, 1'b0);                     // R3: carry left at 1 must be cleared
    chk(!carry_out && sum == 0, "R3", "carry cleared at start", {carry_out, sum}, 0);
    do_add(N'(1) << (N - 1), N'(1) << (N - 1), 1'b1);
    do_add(N'(8'h5A), N'(8'hA5), 1'b1);

    for (int k = 0; k < 40; k++)
      do_add(N'($urandom), N'($urandom), k[0]);

    opnd_a = '1; opnd_b = '1; go = 1'b1;
    for (int k = 0; k < 4; k++) tick();
    rst = 1'b1; go = 1'b0;
    tick();
    chk(!done && !carry_out && sum == 0, "R9", "reset mid-add", {done, carry_out, sum}, 0);
    rst = 1'b0;
    for (int k = 0; k < N + 4; k++) tick();
    chk(!done && sum == 0, "R9", "stays waiting after reset", {done, sum}, 0);
    do_add(N'(8'h3C), N'(8'hC4), 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule